// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

The block watches 32 external input lines and turns selected signal edges into sticky pending flags. Each line can be armed for rising edges, falling edges or both, and a software trigger can force a line pending without any pin activity. Rising-edge hits and falling-edge hits are recorded in two separate pending registers, each cleared by writing ones to it. Pending flags that are enabled in the interrupt mask drive a level-sensitive, active-high interrupt to a parent controller and a matching wakeup request. A separate event mask selects lines whose edges also produce a single-cycle event pulse.

Software reaches the block through a word-wide register port: a write takes effect on the clock edge that samples it, and a read returns its data on `rdata` in the cycle after `rd_en`. A synthesis parameter gives the set of implemented lines; register bits of absent lines are tied to zero, so software finds the implemented lines by writing all ones to the rising-select register and reading it back. External inputs are synchronized by two flops before edge detection, and edge detection stays idle for the first cycles after reset so that a level held through reset never looks like an edge.

Top module: `extint_bank`

## Requirements
- R1: After reset every register reads 0 and `irq_o`, `event_o` and `wake_o` are low.
- R2: Register offsets: rising select 0x00, falling select 0x04, software trigger 0x08, rising pending 0x0C, falling pending 0x10, interrupt mask 0x80, event mask 0x84; line n is bit n of each. Read data appears the cycle after `rd_en`; any other offset reads 0. Bits of unimplemented lines (default `IMPL_MASK` 32'h7FFF_FFFF, line 31 absent) read 0, so writing all ones to 0x00 reads back `IMPL_MASK`.
- R3: A line with only its rising select bit set gets its rising pending bit set on a 0-to-1 input change, and a 1-to-0 change sets nothing.
- R4: A line with only its falling select bit set gets its falling pending bit set on a 1-to-0 change, and a 0-to-1 change sets nothing.
- R5: A line with both select bits set records a rising change in the rising pending register and a falling change in the falling pending register.
- R6: Writing 1 to a pending bit clears it; writing 0 leaves it unchanged; writing all ones clears every flag of that register.
- R7: `irq_o` is high while any rising or falling pending flag of a line whose interrupt mask bit is 1 is set, and low otherwise; a pending flag of a masked line does not raise it.
- R8: Writing 1 to a software-trigger bit sets that line's rising pending flag and the trigger bit reads 1; clearing the rising pending flag clears the trigger bit as well.
- R9: A selected edge that reaches the pending logic in the same cycle as a write-one-to-clear of that flag leaves the flag set.
- R10: `event_o` pulses high for exactly one cycle for each selected edge, or software trigger, of a line whose event mask bit is 1, and stays low for lines whose event mask bit is 0.
- R11: `wake_o` is high exactly when a pending flag of a line with interrupt mask bit 1 is set.
- R12: An unimplemented line never becomes pending, whatever its input or the values written to it.
- R13: An input held high through reset produces no pending flag, even when its rising select is set in the first write after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | 32 | Asynchronous external interrupt lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq_o | output | 1 | Level interrupt to the parent controller |
| event_o | output | 1 | Single-cycle event pulse |
| wake_o | output | 1 | Wakeup request |

## Verification
The assertions watch, on every cycle, that a write-one-to-clear without a coincident hit empties the flag, that a coincident edge survives a clear, that a software-trigger bit never stands without its pending flag, and that the interrupt drops once no enabled flag remains. Edge polarity selection, the line-count probe, event pulse width, the masking of unimplemented lines and the quiet start after reset with a high input are shown only by the bench scenarios, which compare register reads and output levels with values it derives from the input changes it drove.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_RSEL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_FSEL = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SWT  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_RPND = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_FPND = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_IMSK = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_EMSK = 8'h84;
  localparam int ARM_CYC = 3;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/extint_pend.sv
module extint_pend
  import extint_pkg::*;
#(
  parameter int LINES = 32,
  parameter logic [LINES-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] ext_in,
  input  logic [LINES-1:0] rsel,
  input  logic [LINES-1:0] fsel,
  input  logic [LINES-1:0] rclr,
  input  logic [LINES-1:0] fclr,
  input  logic [LINES-1:0] swset,
  output logic [LINES-1:0] rpend,
  output logic [LINES-1:0] fpend,
  output logic [LINES-1:0] hit
);
  logic [LINES-1:0] synced, prev, rhit, fhit;
  logic [ARM_CYC-1:0] arm_q;
  logic armed;

  extint_sync #(.W(LINES)) u_sync (
    .clk(clk), .rst(rst), .d(ext_in), .q(synced)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= '0;
      arm_q <= '0;
    end else begin
      prev  <= synced;
      arm_q <= {arm_q[ARM_CYC-2:0], 1'b1};
    end
  end

  assign armed = arm_q[ARM_CYC-1];
  assign rhit  = {LINES{armed}} & synced & ~prev & rsel & IMPL;
  assign fhit  = {LINES{armed}} & ~synced & prev & fsel & IMPL;
  assign hit   = rhit | fhit;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        rpend[i] <= 1'b0;
        fpend[i] <= 1'b0;
      end else begin
        rpend[i] <= (rpend[i] & ~rclr[i]) | rhit[i] | swset[i];
        fpend[i] <= (fpend[i] & ~fclr[i]) | fhit[i];
      end
    end
  end

  // R6: a clear with no coincident hit empties the flag
  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (|(rclr & ~rhit & ~swset)) |=> ((rpend & $past(rclr & ~rhit & ~swset)) == '0));

  // R9: a hit is never lost, even against a clear
  assert_edge_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (|rhit) |=> ((rpend & $past(rhit)) == $past(rhit)));
endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int LINES = 32,
  parameter logic [LINES-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINES-1:0]  wdata,
  input  logic [LINES-1:0]  rpend,
  input  logic [LINES-1:0]  fpend,
  output logic [LINES-1:0]  rdata,
  output logic [LINES-1:0]  rsel,
  output logic [LINES-1:0]  fsel,
  output logic [LINES-1:0]  imask,
  output logic [LINES-1:0]  emask,
  output logic [LINES-1:0]  rclr,
  output logic [LINES-1:0]  fclr,
  output logic [LINES-1:0]  swset
);
  logic [LINES-1:0] sw_q, wmask;

  assign wmask = wdata & IMPL;
  assign rclr  = (wr_en && addr == OFS_RPND) ? wmask : '0;
  assign fclr  = (wr_en && addr == OFS_FPND) ? wmask : '0;
  assign swset = (wr_en && addr == OFS_SWT)  ? wmask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel  <= '0;
      fsel  <= '0;
      imask <= '0;
      emask <= '0;
      sw_q  <= '0;
    end else begin
      if (wr_en && addr == OFS_RSEL) rsel  <= wmask;
      if (wr_en && addr == OFS_FSEL) fsel  <= wmask;
      if (wr_en && addr == OFS_IMSK) imask <= wmask;
      if (wr_en && addr == OFS_EMSK) emask <= wmask;
      sw_q <= (sw_q | swset) & ~rclr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        OFS_RSEL: rdata <= rsel;
        OFS_FSEL: rdata <= fsel;
        OFS_SWT:  rdata <= sw_q;
        OFS_RPND: rdata <= rpend;
        OFS_FPND: rdata <= fpend;
        OFS_IMSK: rdata <= imask;
        OFS_EMSK: rdata <= emask;
        default:  rdata <= '0;
      endcase
    end
  end

  // R8: a software-trigger bit never stands without its rising pending flag
  assert_sw_backed_R8: assert property (@(posedge clk) disable iff (rst)
    ((sw_q & ~rpend) == '0));
endmodule

// File: rtl/extint_bank.sv
module extint_bank
  import extint_pkg::*;
#(
  parameter int LINES = DATA_W,
  parameter logic [LINES-1:0] IMPL_MASK = 32'h7FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  ext_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LINES-1:0]  wdata,
  output logic [LINES-1:0]  rdata,
  output logic              irq_o,
  output logic              event_o,
  output logic              wake_o
);
  logic [LINES-1:0] rsel, fsel, imask, emask, rclr, fclr, swset;
  logic [LINES-1:0] rpend, fpend, hit;

  extint_regs #(.LINES(LINES), .IMPL(IMPL_MASK)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rpend(rpend), .fpend(fpend), .rdata(rdata),
    .rsel(rsel), .fsel(fsel), .imask(imask), .emask(emask),
    .rclr(rclr), .fclr(fclr), .swset(swset)
  );

  extint_pend #(.LINES(LINES), .IMPL(IMPL_MASK)) u_pend (
    .clk(clk), .rst(rst), .ext_in(ext_in), .rsel(rsel), .fsel(fsel),
    .rclr(rclr), .fclr(fclr), .swset(swset),
    .rpend(rpend), .fpend(fpend), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o   <= 1'b0;
      wake_o  <= 1'b0;
      event_o <= 1'b0;
    end else begin
      irq_o   <= |((rpend | fpend) & imask);
      wake_o  <= |((rpend | fpend) & imask);
      event_o <= |((hit | swset) & emask);
    end
  end

  // R7: with no enabled flag left the interrupt drops
  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (((rpend | fpend) & imask) == '0) |=> !irq_o);
endmodule

// File: tb/tb_extint_bank.sv
`timescale 1ns/1ps
module tb_extint_bank;
  localparam logic [31:0] IMPL = 32'h7FFF_FFFF;
  localparam logic [7:0] A_RSEL = 8'h00, A_FSEL = 8'h04, A_SWT = 8'h08,
    A_RPND = 8'h0C, A_FPND = 8'h10, A_IMSK = 8'h80, A_EMSK = 8'h84;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] ext = 32'hFFFF_FFFF, wdata = 0, rdata;
  logic irq_o, event_o, wake_o;
  int checks = 0, errors = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  extint_bank dut (
    .clk(clk), .rst(rst), .ext_in(ext), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
    .event_o(event_o), .wake_o(wake_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk); ext = v;
    settle();
  endtask

  function automatic logic [31:0] rises(input logic [31:0] o, input logic [31:0] n,
                                        input logic [31:0] s);
    return n & ~o & s & IMPL;
  endfunction

  function automatic logic [31:0] falls(input logic [31:0] o, input logic [31:0] n,
                                        input logic [31:0] s);
    return ~n & o & s & IMPL;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, er, ef, rs, fs, nv, c, im;
    void'($urandom(32'd20240611));
    // R13: inputs held high through reset, rising select written at once
    repeat (4) @(negedge clk);
    rst = 0;
    wr(A_RSEL, 32'hFFFF_FFFF);
    settle();
    rd(A_RPND, d); chk("R13 no spurious pending", d, 32'h0);
    wr(A_RSEL, 32'h0);
    drive(32'h0);
    do_reset();

    // R1: reset state
    rd(A_RSEL, d); chk("R1 rsel", d, 0);
    rd(A_RPND, d); chk("R1 rpend", d, 0);
    rd(A_SWT, d);  chk("R1 swt", d, 0);
    rd(A_IMSK, d); chk("R1 imask", d, 0);
    chk("R1 outputs", {29'd0, irq_o, event_o, wake_o}, 0);

    // R2: line probe and unmapped offset
    wr(A_RSEL, 32'hFFFF_FFFF);
    rd(A_RSEL, d); chk("R2 probe", d, IMPL);
    wr(A_EMSK, 32'hFFFF_FFFF);
    rd(A_EMSK, d); chk("R2 emask readback", d, IMPL);
    wr(A_EMSK, 0);
    rd(8'h40, d); chk("R2 unmapped", d, 0);

    // R12: unimplemented line 31 with both selects
    wr(A_FSEL, 32'hFFFF_FFFF);
    drive(32'h8000_0000); drive(32'h0);
    rd(A_RPND, d); chk("R12 rpend", d, 0);
    rd(A_FPND, d); chk("R12 fpend", d, 0);
    wr(A_SWT, 32'h8000_0000);
    rd(A_RPND, d); chk("R12 swt", d, 0);

    // R3: rising only on line 3
    wr(A_RSEL, 32'h8); wr(A_FSEL, 32'h0);
    drive(32'h8);
    rd(A_RPND, d); chk("R3 rise set", d, 32'h8);
    drive(32'h0);
    rd(A_FPND, d); chk("R3 fall ignored", d, 0);
    wr(A_RPND, 32'hFFFF_FFFF);

    // R4: falling only on line 4
    wr(A_RSEL, 0); wr(A_FSEL, 32'h10);
    drive(32'h10);
    rd(A_RPND, d); chk("R4 rise ignored", d, 0);
    rd(A_FPND, d); chk("R4 rise ignored f", d, 0);
    drive(32'h0);
    rd(A_FPND, d); chk("R4 fall set", d, 32'h10);

    // R6: write 0 keeps, write bit clears, all ones clears all
    wr(A_FPND, 32'h0);
    rd(A_FPND, d); chk("R6 zero write", d, 32'h10);
    wr(A_FPND, 32'h10);
    rd(A_FPND, d); chk("R6 bit clear", d, 0);

    // R5: both edges on line 2
    wr(A_RSEL, 32'h4); wr(A_FSEL, 32'h4);
    drive(32'h4); drive(32'h0);
    rd(A_RPND, d); chk("R5 rise", d, 32'h4);
    rd(A_FPND, d); chk("R5 fall", d, 32'h4);
    wr(A_RPND, 32'hFFFF_FFFF); wr(A_FPND, 32'hFFFF_FFFF);
    rd(A_RPND, d); chk("R6 all ones r", d, 0);
    rd(A_FPND, d); chk("R6 all ones f", d, 0);

    // R9: edge coincident with clear on line 5
    wr(A_RSEL, 32'h20); wr(A_FSEL, 0);
    drive(32'h20); drive(32'h0);
    @(negedge clk); ext = 32'h20;
    @(negedge clk);
    @(negedge clk); wr_en = 1; addr = A_RPND; wdata = 32'h20;
    @(negedge clk); wr_en = 0;
    settle();
    rd(A_RPND, d); chk("R9 flag kept", d, 32'h20);
    wr(A_RPND, 32'h20);
    drive(32'h0);

    // R10: event pulse width
    wr(A_RSEL, 32'hC0); wr(A_EMSK, 32'h40);
    begin
      int cnt = 0;
      @(negedge clk); ext = 32'h40;
      repeat (8) begin @(negedge clk); cnt += int'(event_o); end
      chk("R10 one pulse", cnt, 1);
      cnt = 0;
      @(negedge clk); ext = 32'hC0;
      repeat (8) begin @(negedge clk); cnt += int'(event_o); end
      chk("R10 masked line", cnt, 0);
    end

    // R7 / R11: line 6 and 7 pending, only 6 enabled
    chk("R7 no mask irq", irq_o, 0);
    wr(A_IMSK, 32'h80);
    settle();
    chk("R7 line7 irq", irq_o, 1);
    chk("R11 line7 wake", wake_o, 1);
    wr(A_IMSK, 32'h40);
    settle();
    chk("R7 line6 irq", irq_o, 1);
    wr(A_RPND, 32'h40);
    settle();
    chk("R7 masked pending", irq_o, 0);
    chk("R11 wake low", wake_o, 0);
    wr(A_RPND, 32'hFFFF_FFFF);
    drive(32'h0);

    // R8: software trigger with event
    begin
      int cnt = 0;
      @(negedge clk); wr_en = 1; addr = A_SWT; wdata = 32'h40;
      @(negedge clk); wr_en = 0; cnt += int'(event_o);
      repeat (4) begin @(negedge clk); cnt += int'(event_o); end
      chk("R10 sw event", cnt, 1);
    end
    rd(A_RPND, d); chk("R8 sets rpend", d, 32'h40);
    rd(A_SWT, d);  chk("R8 swt reads", d, 32'h40);
    chk("R7 sw irq", irq_o, 1);
    wr(A_RPND, 32'h40);
    rd(A_SWT, d);  chk("R8 swt cleared", d, 0);
    wr(A_EMSK, 0);

    // random phase covering R3 R4 R5 R6 R7
    er = 0; ef = 0;
    for (int it = 0; it < 60; it++) begin
      rs = $urandom; fs = $urandom; nv = $urandom; im = $urandom;
      wr(A_RSEL, rs); wr(A_FSEL, fs); wr(A_IMSK, im);
      er |= rises(ext, nv, rs);
      ef |= falls(ext, nv, fs);
      drive(nv);
      rd(A_RPND, d); chk("R3 R5 random rise", d, er);
      rd(A_FPND, d); chk("R4 R5 random fall", d, ef);
      chk("R7 random irq", irq_o, |((er | ef) & im & IMPL));
      if (it % 3 == 0) begin
        c = $urandom;
        wr(A_RPND, c); er &= ~c;
        wr(A_FPND, ~c); ef &= c;
        rd(A_RPND, d); chk("R6 random clear r", d, er);
        rd(A_FPND, d); chk("R6 random clear f", d, ef);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule